// File: doc/BRIEF.md
# Streaming Byte-Rotation Permuter for an 8x8 Byte Matrix

The block applies a row-wise cyclic byte rotation to a 64-byte matrix as it streams past. Row `r` of the matrix is rotated right by `r` bytes, so row 0 passes unchanged and row 7 moves by seven positions. The matrix never sits in one wide multiplexed register. It arrives as four 128-bit beats, one per clock. Each beat carries one pair of adjacent columns of every row. The permuted matrix leaves in the same beat format, four clocks after the matching input beat.

Each row has its own lane. A lane is a short chain of beat-wide history registers, and each output byte takes one of two taps from that chain. The choice between the two taps depends only on which beat of the block is being produced. A small phase sequencer counts input beats and delays that count to the output stage, so consecutive blocks stream with no bubble. Idle cycles between blocks are allowed.

Top module: `byterot_dm`

## Requirements
- R1: While `rst_n` is low, and after its release until the first output beat, `out_valid` is 0 and `out_data` is all zeros.
- R2: Bytes in the matrix are numbered row*8+col, with 0 to 63 in row-major order. Output byte (row r, col c) equals input byte (row r, col (c - r) mod 8), which is a right rotation of each row by its row index.
- R3: Beat w (0..3) of a block carries columns 2w and 2w+1 of every row. Byte lane q of the 128-bit bus, at bits [8q+7:8q], holds row q/2, column 2w + (q mod 2). The output bus uses the same layout.
- R4: `out_valid` equals `in_valid` delayed by exactly four clocks. Output beat w of a block appears four clocks after input beat w of the same block.
- R5: Blocks presented on consecutive cycles produce output beats on consecutive cycles with no missing beat.
- R6: The beat counter starts at beat 0 after reset and advances only on cycles with `in_valid` high. A block is four consecutive valid beats, and any number of idle cycles may separate blocks. Data on idle cycles has no effect on the output.
- R7: While `out_valid` is low, `out_data` keeps the value of the last valid output beat.
- R8: For a block whose byte values equal their indices, the first output beat is, lane 0 upward, {0,1,15,8,22,23,29,30,36,37,43,44,50,51,57,58}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat is valid |
| in_data | input | 128 | Input beat: two columns of each of the eight rows |
| out_valid | output | 1 | Output beat is valid |
| out_data | output | 128 | Permuted output beat in the input layout |

## Verification
The bench builds the block with its defaults: 8-bit bytes, eight rows of eight columns, two columns per beat and a rotation step of one, so every rotation amount from 0 to 7 occurs. A walking single-byte block is sent for each of the 64 source positions back to back, which makes every source-to-destination route visible on its own and also streams 64 blocks with no gap. An index-valued block checks the first output beat. Random blocks separated by random idle gaps, with random data driven while idle, exercise phase alignment across gaps and the hold behaviour of the output.

// File: rtl/byterot_pkg.sv
package byterot_pkg;

    // positive modulo
    function automatic int wrap_mod(input int x, input int m);
        return ((x % m) + m) % m;
    endfunction

    // source column feeding output column (bc*w + j) of a row rotated by rot
    function automatic int src_col(input int rot, input int w, input int j,
                                   input int cols, input int bc);
        return wrap_mod(bc * w + j - rot, cols);
    endfunction

    // how many beats back in history the source byte sits when output
    // beat w is registered (0 = the beat on the input bus this cycle)
    function automatic int src_tap(input int rot, input int w, input int j,
                                   input int cols, input int bc);
        int beats;
        beats = cols / bc;
        return (beats - 1) + w - (src_col(rot, w, j, cols, bc) / bc);
    endfunction

    // byte position of the source byte inside its beat
    function automatic int src_lane(input int rot, input int w, input int j,
                                    input int cols, input int bc);
        return src_col(rot, w, j, cols, bc) % bc;
    endfunction

endpackage

// File: rtl/byterot_phase.sv
module byterot_phase #(
    parameter int BEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       sel_valid,
    output logic [$clog2(BEATS)-1:0]   sel_phase
);
    localparam int PH_W = $clog2(BEATS);
    localparam int DLY  = BEATS - 1;

    typedef struct packed {
        logic [PH_W-1:0]            phase;
        logic [DLY-1:0]             vpipe;
        logic [DLY-1:0][PH_W-1:0]   ppipe;
    } ctrl_t;

    ctrl_t q, d;
    logic [PH_W-1:0] phase_now;

    always_comb begin
        d = q;
        if (in_valid) begin
            d.phase = q.phase + 1'b1;
        end
        d.vpipe[0] = in_valid;
        d.ppipe[0] = q.phase;
        for (int i = 1; i < DLY; i++) begin
            d.vpipe[i] = q.vpipe[i-1];
            d.ppipe[i] = q.ppipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign phase_now = q.phase;
    assign sel_valid = q.vpipe[DLY-1];
    assign sel_phase = q.ppipe[DLY-1];

    // R6: the beat counter moves by one on each valid beat
    p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (phase_now == PH_W'($past(phase_now) + 1)));

    // R6: idle cycles leave the beat counter alone
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase_now));

endmodule

// File: rtl/byterot_lane.sv
module byterot_lane
    import byterot_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int COLS      = 8,
    parameter int BEAT_COLS = 2,
    parameter int ROT       = 0,
    parameter int PH_W      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BEAT_COLS*BYTE_W-1:0]   in_bytes,
    input  logic                          sel_valid,
    input  logic [PH_W-1:0]               sel_phase,
    output logic [BEAT_COLS*BYTE_W-1:0]   out_bytes
);
    localparam int BEATS  = COLS / BEAT_COLS;
    localparam int BEAT_W = BEAT_COLS * BYTE_W;
    localparam int HIST   = 2 * BEATS - 2;

    typedef struct packed {
        logic [HIST-1:0][BEAT_W-1:0] hist;
        logic [BEAT_W-1:0]           outb;
    } lane_t;

    lane_t q, d;
    logic [HIST:0][BEAT_W-1:0]   win;
    logic [BEATS-1:0][BEAT_W-1:0] cand;

    always_comb begin
        win[0] = in_bytes;
        for (int i = 1; i <= HIST; i++) begin
            win[i] = q.hist[i-1];
        end
    end

    // per output beat, each byte picks one fixed tap of the history
    for (genvar w = 0; w < BEATS; w++) begin : g_beat
        for (genvar j = 0; j < BEAT_COLS; j++) begin : g_byte
            localparam int TAP = src_tap(ROT, w, j, COLS, BEAT_COLS);
            localparam int LN  = src_lane(ROT, w, j, COLS, BEAT_COLS);
            assign cand[w][j*BYTE_W +: BYTE_W] = win[TAP][LN*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        d = q;
        d.hist[0] = in_bytes;
        for (int i = 1; i < HIST; i++) begin
            d.hist[i] = q.hist[i-1];
        end
        if (sel_valid) begin
            d.outb = cand[sel_phase];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_bytes = q.outb;

    // R7: no output beat scheduled means the lane output does not move
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> $stable(out_bytes));

endmodule

// File: rtl/byterot_dm.sv
module byterot_dm
    import byterot_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int ROWS      = 8,
    parameter int COLS      = 8,
    parameter int BEAT_COLS = 2,
    parameter int ROT_STEP  = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [ROWS*BEAT_COLS*BYTE_W-1:0]   in_data,
    output logic                               out_valid,
    output logic [ROWS*BEAT_COLS*BYTE_W-1:0]   out_data
);
    localparam int BEATS  = COLS / BEAT_COLS;
    localparam int PH_W   = $clog2(BEATS);
    localparam int LANE_W = BEAT_COLS * BYTE_W;

    typedef struct packed {
        logic vld;
    } top_t;

    top_t q, d;
    logic            sel_valid;
    logic [PH_W-1:0] sel_phase;

    byterot_phase #(
        .BEATS (BEATS)
    ) phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sel_valid (sel_valid),
        .sel_phase (sel_phase)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        byterot_lane #(
            .BYTE_W    (BYTE_W),
            .COLS      (COLS),
            .BEAT_COLS (BEAT_COLS),
            .ROT       (wrap_mod(r * ROT_STEP, COLS)),
            .PH_W      (PH_W)
        ) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_bytes  (in_data[r*LANE_W +: LANE_W]),
            .sel_valid (sel_valid),
            .sel_phase (sel_phase),
            .out_bytes (out_data[r*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        d = q;
        d.vld = sel_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.vld;

    // R4: a scheduled beat is presented on the next cycle
    p_out_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> out_valid);

    // R4: no beat scheduled, no valid output
    p_out_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |=> !out_valid);

    // R7: the output bus is frozen across idle output cycles
    p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (out_valid || $stable(out_data)));

endmodule

// File: tb/byterot_dm_tb_top.sv
module byterot_dm_tb_top;
    localparam int BUS_W = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [BUS_W-1:0] in_data = '0;
    logic             out_valid;
    logic [BUS_W-1:0] out_data;

    always #10 clk = ~clk;

    byterot_dm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int cur_kind = 0;

    logic [7:0]       blk [64];
    logic [BUS_W-1:0] exp_d [1024];
    int               exp_c [1024];
    int               exp_k [1024];
    int               hd = 0;
    int               tl = 0;
    logic [BUS_W-1:0] last_out = '0;

    // R3 layout: lane q holds row q/2, column 2w + q%2
    function automatic logic [BUS_W-1:0] in_beat(input int w);
        logic [BUS_W-1:0] v;
        for (int q = 0; q < 16; q++) begin
            v[q*8 +: 8] = blk[(q/2)*8 + 2*w + (q%2)];
        end
        return v;
    endfunction

    // R2 model: out(row, c) = in(row, (c - row) mod 8)
    function automatic logic [BUS_W-1:0] out_beat(input int w);
        logic [BUS_W-1:0] v;
        for (int q = 0; q < 16; q++) begin
            int row;
            int c;
            row = q / 2;
            c   = 2*w + (q%2);
            v[q*8 +: 8] = blk[row*8 + ((c - row + 8) % 8)];
        end
        return v;
    endfunction

    task automatic send_beat(input int w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = in_beat(w);
        exp_d[tl] = out_beat(w);
        exp_c[tl] = cyc + 4;
        exp_k[tl] = cur_kind;
        tl++;
    endtask

    task automatic send_block();
        for (int w = 0; w < 4; w++) send_beat(w);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (mon_en) begin
            n_chk++;
            if (out_valid) begin
                if (hd == tl) begin
                    n_fail++;
                    $display("FAIL R4 unexpected out_valid at cycle %0d: actual 1 expected 0", cyc);
                end else begin
                    if (exp_c[hd] != cyc) begin
                        n_fail++;
                        $display("FAIL R4 latency: actual cycle %0d expected cycle %0d", cyc, exp_c[hd]);
                    end else if (out_data !== exp_d[hd]) begin
                        n_fail++;
                        if (exp_k[hd] == 1)
                            $display("FAIL R8 R2 first beat: actual %h expected %h", out_data, exp_d[hd]);
                        else if (exp_k[hd] == 2)
                            $display("FAIL R6 R2 beat after gap: actual %h expected %h", out_data, exp_d[hd]);
                        else
                            $display("FAIL R2 R3 beat data: actual %h expected %h", out_data, exp_d[hd]);
                    end
                    hd++;
                end
                last_out = out_data;
            end else begin
                if (out_data !== last_out) begin
                    n_fail++;
                    $display("FAIL R7 idle output moved: actual %h expected %h", out_data, last_out);
                end else if (hd != tl && exp_c[hd] <= cyc) begin
                    n_fail++;
                    $display("FAIL R5 missing beat at cycle %0d: actual 0 expected 1", cyc);
                    hd++;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog expired: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        in_data = {$urandom, $urandom, $urandom, $urandom};
        in_valid = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL R1 reset state: actual %b/%h expected 0/0", out_valid, out_data);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL R1 after release: actual %b/%h expected 0/0", out_valid, out_data);
        end
        mon_en = 1'b1;
        idle(5);

        // R8: index-valued block
        cur_kind = 1;
        for (int i = 0; i < 64; i++) blk[i] = 8'(i);
        n_chk++;
        if (out_beat(0) !== {8'd58, 8'd57, 8'd51, 8'd50, 8'd44, 8'd43, 8'd37, 8'd36,
                             8'd30, 8'd29, 8'd23, 8'd22, 8'd8, 8'd15, 8'd1, 8'd0}) begin
            n_fail++;
            $display("FAIL R8 bench model first beat: actual %h", out_beat(0));
        end
        send_block();
        cur_kind = 0;
        idle(6);

        // R2 R5: walking single byte, 64 blocks back to back
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < 64; i++) blk[i] = 8'h00;
            blk[k] = 8'(k + 1) ^ 8'h80;
            send_block();
        end
        idle(6);

        // R6: random blocks separated by random gaps
        cur_kind = 2;
        for (int b = 0; b < 24; b++) begin
            for (int i = 0; i < 64; i++) blk[i] = 8'($urandom);
            send_block();
            idle($urandom % 4);
        end
        cur_kind = 0;

        // R5: random blocks back to back
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 64; i++) blk[i] = 8'($urandom);
            send_block();
        end
        idle(10);

        // R4: every expected beat came out
        n_chk++;
        if (hd != tl) begin
            n_fail++;
            $display("FAIL R4 drained beats: actual %0d expected %0d", hd, tl);
        end
        done = 1'b1;
        mon_en = 1'b0;
        summary();
        $finish;
    end

endmodule